// File: doc/BRIEF.md
# I2C Target with General-Call Recognition

This block is the target side of an I2C link. It is clocked by a fast system clock and oversamples the wired-AND SCL and SDA levels. It recognises START and STOP, gathers the first byte after a START and compares its upper seven bits against an own address set by software. When software allows it, the block also answers the all-zero general call. A matched transfer then moves data bytes MSB first in the direction that the R/W bit selects. The block pulls SDA low for acknowledges and for zero bits it transmits. It pulls SCL low to pause the bus while software deals with a byte.

On the software side, the block takes the own address, a general-call enable, an acknowledge enable, the next transmit byte and a one-cycle service strobe. It returns the last received byte, the bus-busy and direction status, sticky flags for end of byte, STOP and misplaced condition, and an interrupt that is the OR of the sticky flags. The service strobe ends a clock stretch and clears the sticky flags.

Top module: `i2c_slave_gc`

## Requirements
- R1: `busy_o` goes to 1 after a START on the bus and back to 0 after a STOP. Every STOP sets the sticky `stop_flag_o`, and only `svc_i` clears it.
- R2: When the address byte is a write or read to `own_addr_i` (bits 7..1 of the first byte, bit 0 = R/W with 1 = read) and `ack_en_i` is 1, the block pulls SDA low during the 9th clock. With `ack_en_i` at 0 the address is not acknowledged.
- R3: An address byte that is not acknowledged leaves both line drives released, with no stretch and no end-of-byte flag. Later bytes are ignored until the next START.
- R4: The byte 0x00 (general call, write) is acknowledged only while `gc_en_i` is 1. When it is accepted, `gc_call_o` reads 1 for that transfer.
- R5: In a write transfer each data byte is shifted in MSB first and appears on `rx_data_o`. `byte_done_o` is set once the 9th clock falls.
- R6: A received data byte is acknowledged (SDA low on the 9th clock) only if `ack_en_i` is 1. Otherwise SDA stays released, but the byte is still captured.
- R7: When the 9th clock falls after an accepted address, a received byte or a transmitted byte that the master acknowledged, the block holds SCL low until a `svc_i` pulse. That pulse releases SCL and clears `byte_done_o`, `stop_flag_o` and `misplaced_o`.
- R8: In a read transfer the byte on `tx_data_i` at the time of the releasing `svc_i` is sent MSB first. Each bit is valid while SCL is high.
- R9: A master NACK on the 9th clock of a transmitted byte causes no stretch and clears `tx_mode_o`. SDA then stays released until the next START or STOP.
- R10: A START or STOP that comes after the first bit's SCL falling edge and before the 9th falling edge of a byte sets the sticky `misplaced_o`. It also releases both lines and drops the transfer, so a following address byte gets no acknowledge. A START or STOP during the first bit's high phase is legal.
- R11: `tx_mode_o` is 1 exactly while an addressed read transfer is active. `irq_o` is the OR of `byte_done_o`, `stop_flag_o` and `misplaced_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_low_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_low_o | output | 1 | 1 pulls SDA low (ACK or zero bit) |
| own_addr_i | input | 7 | Own 7-bit target address |
| gc_en_i | input | 1 | Allows the general call address |
| ack_en_i | input | 1 | Allows acknowledges |
| tx_data_i | input | 8 | Next byte to transmit |
| svc_i | input | 1 | Service strobe: ends stretch, clears sticky flags |
| rx_data_o | output | 8 | Last received data byte |
| busy_o | output | 1 | Bus between START and STOP |
| byte_done_o | output | 1 | Sticky end-of-byte flag |
| tx_mode_o | output | 1 | Addressed as transmitter |
| stop_flag_o | output | 1 | Sticky STOP flag |
| misplaced_o | output | 1 | Sticky misplaced START/STOP flag |
| gc_call_o | output | 1 | Current transfer used the general call |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the byte-boundary rule in both directions. A START or STOP inside the first bit's high phase (a repeated START or a normal STOP) must pass without an error. A design that counted edges wrong would flag those, or would miss the error on a STOP in the middle of an address. After a misplaced START the bench sends the own address again and expects no acknowledge, because a design that did not drop the transfer would answer it. Other cases are the general call with the enable off and on, a data NACK with `ack_en_i` low where the byte must still land, and a master NACK after which the block must neither stretch nor drive SDA on the next eight clocks. Random transactions with random own addresses, directions and general-call settings are checked against a bench function that predicts the address acknowledge.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = ADDR_W + 1;
    localparam int BIT_CW = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_HOLD,
        ST_RX,
        ST_ACK_RX,
        ST_TX,
        ST_CHK_ACK
    } slv_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    // first byte names this target
    function automatic logic own_match_f(input logic [DATA_W-1:0] first,
                                         input logic [ADDR_W-1:0] own);
        return first[DATA_W-1:1] == own;
    endfunction

    // all-zero byte with general call allowed
    function automatic logic gc_match_f(input logic [DATA_W-1:0] first,
                                        input logic gc_en);
        return gc_en && (first == '0);
    endfunction

    // true once the first bit of a byte has completed and the 9th clock has not yet fallen
    function automatic logic mid_byte_f(input slv_state_e s,
                                        input logic [BIT_CW-1:0] c);
        logic in_bits;
        logic in_ack;
        in_bits = (s == ST_ADDR) || (s == ST_RX) || (s == ST_TX);
        in_ack  = (s == ST_ACK_ADDR) || (s == ST_ACK_RX) || (s == ST_CHK_ACK);
        return (in_bits && (c >= BIT_CW'(2))) || in_ack;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_slave_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LINES = 2;
    localparam int SCL_IX = 1;
    localparam int SDA_IX = 0;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prv <= '1;
        else     prv <= lvl;
    end

    always_comb begin
        ev.scl_rise = lvl[SCL_IX] & ~prv[SCL_IX];
        ev.scl_fall = ~lvl[SCL_IX] & prv[SCL_IX];
        ev.start    = lvl[SCL_IX] & prv[SCL_IX] & prv[SDA_IX] & ~lvl[SDA_IX];
        ev.stop     = lvl[SCL_IX] & prv[SCL_IX] & ~prv[SDA_IX] & lvl[SDA_IX];
        ev.sda      = lvl[SDA_IX];
    end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              svc,
    output logic              scl_low,
    output logic              sda_low,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_mode,
    output logic              gc_call,
    output logic              byte_end,
    output logic              misplaced
);
    slv_state_e        st;
    logic [BIT_CW-1:0] cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rx_q;
    logic              rw_q;
    logic              gc_q;
    logic              mack_q;
    logic              ackdrv_q;
    logic              addressed_q;
    logic              own_hit;
    logic              gc_hit;
    logic              bad_cond;
    logic              last_bit;

    assign own_hit  = own_match_f(shreg, own_addr);
    assign gc_hit   = gc_match_f(shreg, gc_en);
    assign bad_cond = (ev.start | ev.stop) & mid_byte_f(st, cnt);
    assign last_bit = (cnt == BIT_CW'(DATA_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            rx_q        <= '0;
            rw_q        <= 1'b0;
            gc_q        <= 1'b0;
            mack_q      <= 1'b0;
            ackdrv_q    <= 1'b0;
            addressed_q <= 1'b0;
            byte_end    <= 1'b0;
            misplaced   <= 1'b0;
        end else begin
            byte_end  <= 1'b0;
            misplaced <= 1'b0;
            if (bad_cond) begin
                st          <= ST_IDLE;
                cnt         <= '0;
                addressed_q <= 1'b0;
                misplaced   <= 1'b1;
            end else if (ev.start) begin
                st          <= ST_ADDR;
                cnt         <= '0;
                addressed_q <= 1'b0;
            end else if (ev.stop) begin
                st          <= ST_IDLE;
                cnt         <= '0;
                addressed_q <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg <= {shreg[DATA_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.scl_fall && last_bit) begin
                            cnt <= '0;
                            if ((own_hit || gc_hit) && ack_en) begin
                                st   <= ST_ACK_ADDR;
                                rw_q <= shreg[0];
                                gc_q <= gc_hit && !own_hit;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (ev.scl_fall) begin
                            st          <= ST_HOLD;
                            addressed_q <= 1'b1;
                            byte_end    <= 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (svc) begin
                            cnt <= '0;
                            if (rw_q) begin
                                st    <= ST_TX;
                                shreg <= tx_data;
                            end else begin
                                st <= ST_RX;
                            end
                        end
                    end
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            shreg <= {shreg[DATA_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.scl_fall && last_bit) begin
                            rx_q     <= shreg;
                            ackdrv_q <= ack_en;
                            cnt      <= '0;
                            st       <= ST_ACK_RX;
                        end
                    end
                    ST_ACK_RX: begin
                        if (ev.scl_fall) begin
                            st       <= ST_HOLD;
                            byte_end <= 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (last_bit) begin
                                st  <= ST_CHK_ACK;
                                cnt <= '0;
                            end else begin
                                shreg <= {shreg[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_CHK_ACK: begin
                        if (ev.scl_rise) begin
                            mack_q <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            byte_end <= 1'b1;
                            if (mack_q) begin
                                st <= ST_HOLD;
                            end else begin
                                st          <= ST_IDLE;
                                addressed_q <= 1'b0;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign scl_low = (st == ST_HOLD);
    assign sda_low = (st == ST_ACK_ADDR)
                   || ((st == ST_ACK_RX) && ackdrv_q)
                   || ((st == ST_TX) && !shreg[DATA_W-1]);
    assign rx_data = rx_q;
    assign tx_mode = rw_q & addressed_q;
    assign gc_call = gc_q & addressed_q;

    AST_ADDR_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK_ADDR && $past(st) == ST_ADDR) |-> $past(ack_en)); // R2

    AST_RX_ONLY_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_q) |-> ($past(st) == ST_RX)); // R5

endmodule

// File: rtl/i2c_slave_flags.sv
module i2c_slave_flags #(
    parameter int N_STICKY = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_ev,
    input  logic                stop_ev,
    input  logic [N_STICKY-1:0] set_ev,
    input  logic                svc,
    output logic                busy,
    output logic [N_STICKY-1:0] sticky,
    output logic                irq
);
    always_ff @(posedge clk) begin
        if (rst)           busy <= 1'b0;
        else if (start_ev) busy <= 1'b1;
        else if (stop_ev)  busy <= 1'b0;
    end

    for (genvar g = 0; g < N_STICKY; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) sticky[g] <= 1'b0;
            else     sticky[g] <= set_ev[g] | (sticky[g] & ~svc);
        end
    end

    assign irq = |sticky;

endmodule

// File: rtl/i2c_slave_gc.sv
module i2c_slave_gc
    import i2c_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              ack_en_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              svc_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              busy_o,
    output logic              byte_done_o,
    output logic              tx_mode_o,
    output logic              stop_flag_o,
    output logic              misplaced_o,
    output logic              gc_call_o,
    output logic              irq_o
);
    localparam int N_STICKY = 3;

    bus_ev_t             ev;
    logic                byte_end;
    logic                misplaced;
    logic [N_STICKY-1:0] sticky;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_slave_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .own_addr  (own_addr_i),
        .gc_en     (gc_en_i),
        .ack_en    (ack_en_i),
        .tx_data   (tx_data_i),
        .svc       (svc_i),
        .scl_low   (scl_low_o),
        .sda_low   (sda_low_o),
        .rx_data   (rx_data_o),
        .tx_mode   (tx_mode_o),
        .gc_call   (gc_call_o),
        .byte_end  (byte_end),
        .misplaced (misplaced)
    );

    i2c_slave_flags #(.N_STICKY(N_STICKY)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .start_ev (ev.start),
        .stop_ev  (ev.stop),
        .set_ev   ({misplaced, ev.stop, byte_end}),
        .svc      (svc_i),
        .busy     (busy_o),
        .sticky   (sticky),
        .irq      (irq_o)
    );

    assign byte_done_o = sticky[0];
    assign stop_flag_o = sticky[1];
    assign misplaced_o = sticky[2];

    AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (scl_low_o && !svc_i) |=> scl_low_o); // R7

    AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (scl_low_o && svc_i) |=> !scl_low_o); // R7

    AST_ERR_RELEASES_LINES: assert property (@(posedge clk) disable iff (rst)
        $rose(misplaced_o) |-> (!sda_low_o && !scl_low_o)); // R10

    AST_BYTE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_done_o) |-> busy_o); // R1

endmodule

// File: tb/i2c_slave_gc_tb.sv
module i2c_slave_gc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WD_CYCLES  = 180000;
    localparam int N_RAND     = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_bus, sda_bus;
    logic       scl_low, sda_low;
    logic [6:0] own_addr = 7'h3A;
    logic       gc_en = 1'b0;
    logic       ack_en = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       svc = 1'b0;
    logic [7:0] rx_data;
    logic       busy, byte_done, tx_mode, stop_flag, misplaced, gc_call, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_bus = scl_m & ~scl_low;
    assign sda_bus = sda_m & ~sda_low;

    i2c_slave_gc u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_bus),
        .sda_i       (sda_bus),
        .scl_low_o   (scl_low),
        .sda_low_o   (sda_low),
        .own_addr_i  (own_addr),
        .gc_en_i     (gc_en),
        .ack_en_i    (ack_en),
        .tx_data_i   (tx_data),
        .svc_i       (svc),
        .rx_data_o   (rx_data),
        .busy_o      (busy),
        .byte_done_o (byte_done),
        .tx_mode_o   (tx_mode),
        .stop_flag_o (stop_flag),
        .misplaced_o (misplaced),
        .gc_call_o   (gc_call),
        .irq_o       (irq)
    );

    function automatic logic f_addr_ack(input logic [7:0] b, input logic [6:0] own,
                                        input logic gce, input logic acke);
        return acke && ((b[7:1] == own) || (gce && b == 8'h00));
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic svc_pulse();
        svc = 1'b1;
        tick(1);
        svc = 1'b0;
        tick(2);
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic m_bit(input logic b, output logic got);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        got = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_xfer(input logic [7:0] o, output logic [7:0] i);
        logic g;
        for (int k = 7; k >= 0; k--) begin
            m_bit(o[k], g);
            i[k] = g;
        end
    endtask

    task automatic m_write_byte(input logic [7:0] d, output logic ack);
        logic [7:0] dummy;
        logic g;
        m_xfer(d, dummy);
        m_bit(1'b1, g);
        ack = ~g;
    endtask

    task automatic m_read_byte(input logic mack, output logic [7:0] d);
        logic g;
        m_xfer(8'hFF, d);
        m_bit(~mack, g);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       ack;
        logic       g;
        logic [7:0] d;
        void'($urandom(32'd9157));
        tick(5);
        rst = 1'b0;
        tick(3);

        chk("R1 busy after reset", busy, 0);
        chk("R7 scl released after reset", scl_low, 0);
        chk("R3 sda released after reset", sda_low, 0);
        chk("R11 irq after reset", irq, 0);

        // write to own address, three data bytes
        m_start();
        chk("R1 busy after START", busy, 1);
        m_write_byte({7'h3A, 1'b0}, ack);
        chk("R2 own write address acked", ack, 1);
        chk("R7 stretch after address", scl_low, 1);
        chk("R11 tx_mode on write", tx_mode, 0);
        chk("R11 irq with byte_done", irq, 1);
        chk("R4 gc_call on own address", gc_call, 0);
        svc_pulse();
        chk("R7 svc releases SCL", scl_low, 0);
        chk("R7 svc clears byte_done", byte_done, 0);
        m_write_byte(8'hA5, ack);
        chk("R6 data acked with enable", ack, 1);
        chk("R5 rx_data first byte", rx_data, 8'hA5);
        chk("R5 byte_done after 9th clock", byte_done, 1);
        svc_pulse();
        ack_en = 1'b0;
        m_write_byte(8'h3C, ack);
        chk("R6 data NACK when disabled", ack, 0);
        chk("R6 byte captured despite NACK", rx_data, 8'h3C);
        chk("R7 stretch after NACKed byte", scl_low, 1);
        svc_pulse();
        ack_en = 1'b1;
        m_stop();
        chk("R1 busy cleared by STOP", busy, 0);
        chk("R1 stop flag set", stop_flag, 1);
        chk("R10 no error on boundary STOP", misplaced, 0);
        svc_pulse();
        chk("R1 stop flag cleared by svc", stop_flag, 0);

        // address mismatch
        m_start();
        m_write_byte({7'h3B, 1'b0}, ack);
        chk("R3 mismatch not acked", ack, 0);
        chk("R3 no stretch on mismatch", scl_low, 0);
        chk("R3 no byte_done on mismatch", byte_done, 0);
        m_write_byte(8'h00, ack);
        chk("R3 later byte ignored", ack, 0);
        m_stop();
        svc_pulse();

        // address with ack disabled
        ack_en = 1'b0;
        m_start();
        m_write_byte({7'h3A, 1'b0}, ack);
        chk("R2 address NACK when disabled", ack, 0);
        chk("R3 no stretch when address NACKed", scl_low, 0);
        m_stop();
        svc_pulse();
        ack_en = 1'b1;

        // general call
        m_start();
        m_write_byte(8'h00, ack);
        chk("R4 general call ignored when disabled", ack, 0);
        m_stop();
        svc_pulse();
        gc_en = 1'b1;
        m_start();
        m_write_byte(8'h00, ack);
        chk("R4 general call acked when enabled", ack, 1);
        chk("R4 gc_call flag", gc_call, 1);
        svc_pulse();
        m_write_byte(8'h5A, ack);
        chk("R5 rx_data after general call", rx_data, 8'h5A);
        svc_pulse();
        m_stop();
        svc_pulse();
        gc_en = 1'b0;

        // read: master acks, then NACKs
        m_start();
        m_write_byte({7'h3A, 1'b1}, ack);
        chk("R2 own read address acked", ack, 1);
        chk("R11 tx_mode on read", tx_mode, 1);
        chk("R7 stretch before first tx byte", scl_low, 1);
        tx_data = 8'hC3;
        svc_pulse();
        m_read_byte(1'b1, d);
        chk("R8 first tx byte", d, 8'hC3);
        chk("R7 stretch after master ACK", scl_low, 1);
        tx_data = 8'h1E;
        svc_pulse();
        m_read_byte(1'b0, d);
        chk("R8 second tx byte", d, 8'h1E);
        chk("R9 no stretch after NACK", scl_low, 0);
        chk("R9 tx_mode cleared after NACK", tx_mode, 0);
        m_xfer(8'hFF, d);
        chk("R9 SDA released after NACK", d, 8'hFF);
        m_stop();
        svc_pulse();

        // repeated START at a byte boundary
        m_start();
        m_write_byte({7'h3A, 1'b0}, ack);
        svc_pulse();
        m_write_byte(8'h11, ack);
        svc_pulse();
        m_start();
        chk("R10 no error on boundary repeated START", misplaced, 0);
        m_write_byte({7'h3A, 1'b1}, ack);
        chk("R2 address after repeated START acked", ack, 1);
        tx_data = 8'h80;
        svc_pulse();
        m_read_byte(1'b0, d);
        chk("R8 tx byte after repeated START", d, 8'h80);
        m_stop();
        svc_pulse();

        // misplaced START inside a data byte
        m_start();
        m_write_byte({7'h3A, 1'b0}, ack);
        svc_pulse();
        m_bit(1'b1, g);
        m_bit(1'b0, g);
        m_bit(1'b1, g);
        m_start();
        chk("R10 misplaced START flagged", misplaced, 1);
        chk("R11 irq on misplaced", irq, 1);
        chk("R10 lines released after error", {scl_low, sda_low}, 0);
        m_write_byte({7'h3A, 1'b0}, ack);
        chk("R10 transfer abandoned", ack, 0);
        m_stop();
        svc_pulse();
        chk("R7 svc clears misplaced", misplaced, 0);

        // misplaced STOP inside the address byte
        m_start();
        for (int k = 0; k < 4; k++) m_bit(k[0], g);
        m_stop();
        chk("R10 misplaced STOP flagged", misplaced, 1);
        chk("R1 busy cleared by misplaced STOP", busy, 0);
        svc_pulse();

        // random transactions
        for (int n = 0; n < N_RAND; n++) begin
            logic [6:0] a7;
            logic       rw;
            logic       hit;
            logic [7:0] dat;
            own_addr = 7'(1 + ($urandom % 127));
            gc_en    = 1'($urandom % 2);
            rw       = 1'($urandom % 2);
            dat      = 8'($urandom);
            if (($urandom % 3) != 0) a7 = own_addr;
            else                     a7 = own_addr ^ 7'(1 + ($urandom % 127));
            if (($urandom % 5) == 0) begin a7 = 7'h00; rw = 1'b0; end
            hit = f_addr_ack({a7, rw}, own_addr, gc_en, 1'b1);
            m_start();
            m_write_byte({a7, rw}, ack);
            chk("R2 random address ack", ack, hit);
            chk("R7 random stretch follows ack", scl_low, hit);
            if (hit && !rw) begin
                svc_pulse();
                m_write_byte(dat, ack);
                chk("R6 random data ack", ack, 1);
                chk("R5 random rx_data", rx_data, dat);
                svc_pulse();
            end else if (hit && rw) begin
                tx_data = dat;
                svc_pulse();
                m_read_byte(1'b0, d);
                chk("R8 random tx byte", d, dat);
            end else begin
                m_xfer(8'hFF, d);
                chk("R3 random mismatch keeps SDA released", d, 8'hFF);
            end
            m_stop();
            chk("R1 random busy cleared", busy, 0);
            svc_pulse();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule